// File: doc/BRIEF.md
# Fetch Request Dispatcher with Per-Kind Queues

This block sits between the thread sequencer and two fetch execution units, one for vertex fetches and one for texture fetches. It takes one fetch request per cycle in program order. Each request carries a kind bit and a tag. The block holds requests in small queues and hands each one to the unit of its kind as soon as that unit is free. It can hand out up to two requests per cycle, one to each unit. Fetch issue runs on its own and does not wait on arithmetic issue. Each unit is modelled as a busy counter. A dispatch loads the counter from that unit's configured latency. Memory traffic and returned data are not modelled.

The compile-time parameter `UNIFIED` picks the queue layout. With `UNIFIED=0`, each kind has its own queue of `QDEPTH` entries. With `UNIFIED=1`, a single queue of `2*QDEPTH` entries, served in order, feeds both units. The same request stream can therefore be replayed on both layouts and the two compared.

To support that comparison, a run meter counts the cycles of each run. A run starts with the first accepted request and ends when the queues and both units have drained. The meter is a three-state machine:
- `MTR_IDLE` is the state after reset. It moves to `MTR_ACTIVE` on an accept.
- `MTR_ACTIVE` counts. It moves to `MTR_DRAINED` in a cycle where everything is empty and nothing is accepted.
- `MTR_DRAINED` holds the count. It returns to `MTR_ACTIVE` on the next accept.

Top module: `fetch_dispatch`

## Requirements
- R1: With `UNIFIED=0`, `req_kind` 0 selects the vertex queue and 1 selects the texture queue. `req_ready` is low while the selected queue holds `QDEPTH` entries. A request that is offered while `req_ready` is low is not taken, and it stays on the input until it is accepted.
- R2: With `UNIFIED=1`, one shared queue holds up to `2*QDEPTH` requests of either kind, and `req_ready` is low while it is full.
- R3: A request is never issued in the cycle in which it is accepted. Every accepted request is issued exactly once. Requests of the same kind are issued in the order they were accepted.
- R4: After a vertex issue, no further vertex issue occurs for `VTX_LAT-1` cycles. After a texture issue, no further texture issue occurs for `TEX_LAT-1` cycles. Each unit is free again `VTX_LAT` or `TEX_LAT` cycles after its issue.
- R5: With `UNIFIED=0`, the two queues dispatch independently. A blocked vertex head never holds back a ready texture head, and the reverse also holds. Both may issue in the same cycle.
- R6: With `UNIFIED=1`, only the first entry, or the first two entries, may issue. The second entry issues only in the same cycle as the first, and only if it is of the other kind and that kind's unit is free. While the first entry waits, nothing behind it issues.
- R7: `run_cycles` counts every cycle from the accepting cycle through the last cycle in which a queue or a unit is still busy. `run_done` then rises, and both outputs hold until the next accept.
- R8: After reset, `run_cycles` is 0, `run_done` is 0, neither issue output is high, and `req_ready` is high.
- R9: An accept while `run_done` is high starts a new run. `run_cycles` becomes 1 in the next cycle and `run_done` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_kind | input | 1 | 0 = vertex fetch, 1 = texture fetch |
| req_tag | input | TAG_W | Request identifier |
| req_ready | output | 1 | The offered request is taken this cycle |
| vtx_issue | output | 1 | A request goes to the vertex unit this cycle |
| vtx_tag | output | TAG_W | Tag of the vertex request being issued |
| tex_issue | output | 1 | A request goes to the texture unit this cycle |
| tex_tag | output | TAG_W | Tag of the texture request being issued |
| run_cycles | output | CNT_W | Length of the current or last run, in cycles |
| run_done | output | 1 | The last run has fully drained |

## Verification
The hardest case to reach is a shared-queue head that is held back by a busy vertex unit while texture requests pile up behind it. That case is followed by a same-cycle dual issue once the vertex unit frees.

The stimulus gets there with the pattern vertex, vertex, vertex, texture, texture, texture at a vertex latency of 2. That stream is replayed on both layouts. The split layout must finish one cycle sooner than the shared one, and each layout must show exactly one dual-issue cycle.

A long all-vertex burst then fills the shared queue to force a stall. A vertex burst fills the split queue to force one there too.

// File: rtl/fetch_disp_pkg.sv
package fetch_disp_pkg;

    typedef enum logic {
        KIND_VTX = 1'b0,
        KIND_TEX = 1'b1
    } fetch_kind_e;

    typedef enum logic [1:0] {
        MTR_IDLE    = 2'd0,
        MTR_ACTIVE  = 2'd1,
        MTR_DRAINED = 2'd2
    } meter_state_e;

endpackage

// File: rtl/fetch_fifo.sv
module fetch_fifo #(
    parameter int DEPTH  = 2,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [1:0]        pop_n,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] head0,
    output logic [DATA_W-1:0] head1
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;

    // shift out popped entries, then append the new one behind the survivors
    always_comb begin
        int base;
        base = int'(cnt_q) - int'(pop_n);
        for (int i = 0; i < DEPTH; i++) begin
            if (i + int'(pop_n) < DEPTH) begin
                mem_d[i] = mem_q[i + int'(pop_n)];
            end else begin
                mem_d[i] = mem_q[i];
            end
        end
        if (push) begin
            mem_d[base] = push_data;
        end
        cnt_d = CNT_W'(base + int'(push));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end

    assign count = cnt_q;
    assign head0 = mem_q[0];
    assign head1 = mem_q[1];

endmodule

// File: rtl/fetch_unit_timer.sv
module fetch_unit_timer #(
    parameter int LAT = 2,
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic free
);

    localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

    logic [CW-1:0] busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (start) begin
            busy_q <= LOAD;
        end else if (busy_q != '0) begin
            busy_q <= busy_q - 1'b1;
        end
    end

    assign free = (busy_q == '0);

endmodule

// File: rtl/fetch_run_meter.sv
module fetch_run_meter
    import fetch_disp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             drained,
    output logic [CNT_W-1:0] cycles,
    output logic             done
);

    meter_state_e     st_q;
    meter_state_e     st_d;
    logic [CNT_W-1:0] cyc_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MTR_IDLE:    if (accept) st_d = MTR_ACTIVE;
            MTR_ACTIVE:  if (drained && !accept) st_d = MTR_DRAINED;
            MTR_DRAINED: if (accept) st_d = MTR_ACTIVE;
            default:     st_d = MTR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= MTR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (st_q != MTR_ACTIVE && accept) begin
            cyc_q <= CNT_W'(1);
        end else if (st_q == MTR_ACTIVE && st_d == MTR_ACTIVE && cyc_q != '1) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    always_comb begin
        cycles = cyc_q;
        done   = (st_q == MTR_DRAINED);
    end

endmodule

// File: rtl/fetch_dispatch.sv
module fetch_dispatch
    import fetch_disp_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int QDEPTH  = 2,
    parameter int VTX_LAT = 2,
    parameter int TEX_LAT = 1,
    parameter int UNIFIED = 0,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_kind,
    input  logic [TAG_W-1:0] req_tag,
    output logic             req_ready,
    output logic             vtx_issue,
    output logic [TAG_W-1:0] vtx_tag,
    output logic             tex_issue,
    output logic [TAG_W-1:0] tex_tag,
    output logic [CNT_W-1:0] run_cycles,
    output logic             run_done
);

    localparam int UQ_DEPTH = 2 * QDEPTH;
    localparam int ENT_W    = TAG_W + 1;
    localparam int SC_W     = $clog2(QDEPTH + 1);
    localparam int UC_W     = $clog2(UQ_DEPTH + 1);

    fetch_kind_e in_kind;
    logic        accept;
    logic        vtx_free;
    logic        tex_free;
    logic        queues_empty;
    logic        drained;

    assign in_kind = fetch_kind_e'(req_kind);
    assign accept  = req_valid && req_ready;

    generate
        if (UNIFIED == 0) begin : g_split
            localparam logic [SC_W-1:0] FULL = SC_W'(QDEPTH);

            logic [SC_W-1:0]  v_count;
            logic [SC_W-1:0]  t_count;
            logic [TAG_W-1:0] v_head;
            logic [TAG_W-1:0] t_head;
            logic [TAG_W-1:0] v_head1_unused;
            logic [TAG_W-1:0] t_head1_unused;
            logic             v_go;
            logic             t_go;

            assign v_go = (v_count != '0) && vtx_free;
            assign t_go = (t_count != '0) && tex_free;

            fetch_fifo #(.DEPTH(QDEPTH), .DATA_W(TAG_W)) u_vtx_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (accept && (in_kind == KIND_VTX)),
                .push_data (req_tag),
                .pop_n     ({1'b0, v_go}),
                .count     (v_count),
                .head0     (v_head),
                .head1     (v_head1_unused)
            );

            fetch_fifo #(.DEPTH(QDEPTH), .DATA_W(TAG_W)) u_tex_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (accept && (in_kind == KIND_TEX)),
                .push_data (req_tag),
                .pop_n     ({1'b0, t_go}),
                .count     (t_count),
                .head0     (t_head),
                .head1     (t_head1_unused)
            );

            assign req_ready    = (in_kind == KIND_VTX) ? (v_count != FULL) : (t_count != FULL);
            assign vtx_issue    = v_go;
            assign vtx_tag      = v_head;
            assign tex_issue    = t_go;
            assign tex_tag      = t_head;
            assign queues_empty = (v_count == '0) && (t_count == '0);
        end else begin : g_unified
            localparam logic [UC_W-1:0] FULL = UC_W'(UQ_DEPTH);

            logic [UC_W-1:0]  u_count;
            logic [ENT_W-1:0] h0;
            logic [ENT_W-1:0] h1;
            fetch_kind_e      k0;
            fetch_kind_e      k1;
            logic             free0;
            logic             free1;
            logic             go0;
            logic             go1;
            logic             v_from0;
            logic             t_from0;

            assign k0    = fetch_kind_e'(h0[TAG_W]);
            assign k1    = fetch_kind_e'(h1[TAG_W]);
            assign free0 = (k0 == KIND_VTX) ? vtx_free : tex_free;
            assign free1 = (k1 == KIND_VTX) ? vtx_free : tex_free;

            // head first; the next entry rides along only onto the other unit
            assign go0 = (u_count != '0) && free0;
            assign go1 = go0 && (u_count >= UC_W'(2)) && (k1 != k0) && free1;

            fetch_fifo #(.DEPTH(UQ_DEPTH), .DATA_W(ENT_W)) u_shared_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (accept),
                .push_data ({req_kind, req_tag}),
                .pop_n     ({1'b0, go0} + {1'b0, go1}),
                .count     (u_count),
                .head0     (h0),
                .head1     (h1)
            );

            assign v_from0      = go0 && (k0 == KIND_VTX);
            assign t_from0      = go0 && (k0 == KIND_TEX);
            assign vtx_issue    = v_from0 || (go1 && (k1 == KIND_VTX));
            assign tex_issue    = t_from0 || (go1 && (k1 == KIND_TEX));
            assign vtx_tag      = v_from0 ? h0[TAG_W-1:0] : h1[TAG_W-1:0];
            assign tex_tag      = t_from0 ? h0[TAG_W-1:0] : h1[TAG_W-1:0];
            assign req_ready    = (u_count != FULL);
            assign queues_empty = (u_count == '0);
        end
    endgenerate

    fetch_unit_timer #(.LAT(VTX_LAT)) u_vtx_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (vtx_issue),
        .free  (vtx_free)
    );

    fetch_unit_timer #(.LAT(TEX_LAT)) u_tex_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tex_issue),
        .free  (tex_free)
    );

    assign drained = queues_empty && vtx_free && tex_free;

    fetch_run_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .drained (drained),
        .cycles  (run_cycles),
        .done    (run_done)
    );

endmodule

// File: rtl/fetch_dispatch_chk.sv
module fetch_dispatch_chk #(
    parameter int QDEPTH  = 2,
    parameter int VTX_LAT = 2,
    parameter int TEX_LAT = 1,
    parameter int UNIFIED = 0,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_kind,
    input logic             req_ready,
    input logic             vtx_issue,
    input logic             tex_issue,
    input logic [CNT_W-1:0] run_cycles,
    input logic             run_done
);

    int   pend_v;
    int   pend_t;
    int   gap_v;
    int   gap_t;
    logic acc;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v <= 0;
            pend_t <= 0;
            gap_v  <= 0;
            gap_t  <= 0;
        end else begin
            pend_v <= pend_v + ((acc && !req_kind) ? 1 : 0) - (vtx_issue ? 1 : 0);
            pend_t <= pend_t + ((acc && req_kind) ? 1 : 0) - (tex_issue ? 1 : 0);
            gap_v  <= vtx_issue ? (VTX_LAT - 1) : ((gap_v > 0) ? gap_v - 1 : 0);
            gap_t  <= tex_issue ? (TEX_LAT - 1) : ((gap_t > 0) ? gap_t - 1 : 0);
        end
    end

    assert_vtx_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_v != 0) |-> !vtx_issue)
        else $error("vertex unit reissued while busy");

    assert_tex_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_t != 0) |-> !tex_issue)
        else $error("texture unit reissued while busy");

    assert_vtx_has_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vtx_issue |-> (pend_v > 0))
        else $error("vertex issue without an earlier accepted request");

    assert_tex_has_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tex_issue |-> (pend_t > 0))
        else $error("texture issue without an earlier accepted request");

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && !acc) |=> (run_done && $stable(run_cycles)))
        else $error("drained run result changed without an accept");

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && acc) |=> (!run_done && run_cycles == CNT_W'(1)))
        else $error("new run did not restart the counter");

    generate
        if (UNIFIED == 0) begin : g_split_chk
            assert_vtx_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (!req_kind && pend_v >= QDEPTH) |-> !req_ready)
                else $error("vertex queue overfilled");
            assert_tex_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (req_kind && pend_t >= QDEPTH) |-> !req_ready)
                else $error("texture queue overfilled");
        end else begin : g_shared_chk
            assert_shared_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_v + pend_t >= 2 * QDEPTH) |-> !req_ready)
                else $error("shared queue overfilled");
        end
    endgenerate

endmodule

bind fetch_dispatch fetch_dispatch_chk #(
    .QDEPTH  (QDEPTH),
    .VTX_LAT (VTX_LAT),
    .TEX_LAT (TEX_LAT),
    .UNIFIED (UNIFIED),
    .CNT_W   (CNT_W)
) u_fetch_dispatch_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_ready  (req_ready),
    .vtx_issue  (vtx_issue),
    .tex_issue  (tex_issue),
    .run_cycles (run_cycles),
    .run_done   (run_done)
);

// File: tb/fetch_dispatch_bench.sv
module fetch_dispatch_bench;

    localparam int VL = 2;
    localparam int TL = 1;

    logic       clk;
    logic       rst_n;
    logic       rv [2];
    logic       rk [2];
    logic [7:0] rt [2];
    logic       rr [2];
    logic       vi [2];
    logic [7:0] vt [2];
    logic       ti [2];
    logic [7:0] tt [2];
    logic [15:0] rc [2];
    logic       rd [2];

    int n_checks;
    int n_errors;
    int cyc;
    int next_tag;
    int dual_cnt [2];
    int last_v [2];
    int last_t [2];
    int exp_v0 [$];
    int exp_t0 [$];
    int exp_v1 [$];
    int exp_t1 [$];

    fetch_dispatch #(.VTX_LAT(VL), .TEX_LAT(TL), .UNIFIED(0)) u_fetch_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_kind(rk[0]), .req_tag(rt[0]),
        .req_ready(rr[0]), .vtx_issue(vi[0]), .vtx_tag(vt[0]), .tex_issue(ti[0]),
        .tex_tag(tt[0]), .run_cycles(rc[0]), .run_done(rd[0])
    );

    fetch_dispatch #(.VTX_LAT(VL), .TEX_LAT(TL), .UNIFIED(1)) u_fetch_dispatch_uni (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_kind(rk[1]), .req_tag(rt[1]),
        .req_ready(rr[1]), .vtx_issue(vi[1]), .vtx_tag(vt[1]), .tex_issue(ti[1]),
        .tex_tag(tt[1]), .run_cycles(rc[1]), .run_done(rd[1])
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    initial begin
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input int m, input bit k, input int tag);
        if (m == 0 && !k) exp_v0.push_back(tag);
        if (m == 0 && k)  exp_t0.push_back(tag);
        if (m == 1 && !k) exp_v1.push_back(tag);
        if (m == 1 && k)  exp_t1.push_back(tag);
    endtask

    function automatic int pop_exp(input int m, input bit k);
        int r;
        r = -1;
        if (m == 0 && !k && exp_v0.size() > 0) r = exp_v0.pop_front();
        if (m == 0 && k && exp_t0.size() > 0)  r = exp_t0.pop_front();
        if (m == 1 && !k && exp_v1.size() > 0) r = exp_v1.pop_front();
        if (m == 1 && k && exp_t1.size() > 0)  r = exp_t1.pop_front();
        return r;
    endfunction

    function automatic int left_exp(input int m);
        if (m == 0) return exp_v0.size() + exp_t0.size();
        return exp_v1.size() + exp_t1.size();
    endfunction

    // monitor: pops expected tags per kind and checks unit spacing
    initial begin
        forever begin
            @(negedge clk);
            #3;
            for (int m = 0; m < 2; m++) begin
                if (vi[m]) begin
                    int e;
                    e = pop_exp(m, 1'b0);
                    check(e == int'(vt[m]), "R3", "vertex tag order", int'(vt[m]), e);
                    if (last_v[m] >= 0)
                        check(cyc - last_v[m] >= VL, "R4", "vertex issue spacing", cyc - last_v[m], VL);
                    last_v[m] = cyc;
                end
                if (ti[m]) begin
                    int e;
                    e = pop_exp(m, 1'b1);
                    check(e == int'(tt[m]), "R3", "texture tag order", int'(tt[m]), e);
                    if (last_t[m] >= 0)
                        check(cyc - last_t[m] >= TL, "R4", "texture issue spacing", cyc - last_t[m], TL);
                    last_t[m] = cyc;
                end
                if (vi[m] && ti[m]) dual_cnt[m]++;
            end
        end
    end

    // driver: offer one request at a negedge, hold it until taken
    task automatic send(input int m, input bit k, inout int stalls);
        int tag;
        tag = next_tag;
        next_tag++;
        rv[m] = 1'b1;
        rk[m] = k;
        rt[m] = 8'(tag);
        push_exp(m, k, tag);
        forever begin
            #2;
            if (rr[m]) begin
                @(negedge clk);
                break;
            end
            stalls++;
            @(negedge clk);
        end
    endtask

    task automatic run_seq(input int m, input string pat, input int exp_cyc, input int exp_stall,
                           input int exp_dual, input string req_cyc, input string req_stall,
                           input string req_dual);
        int stalls;
        stalls = 0;
        dual_cnt[m] = 0;
        @(negedge clk);
        for (int i = 0; i < pat.len(); i++) begin
            send(m, (pat[i] == "T"), stalls);
        end
        rv[m] = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            #1;
            if (rd[m]) break;
        end
        check(rc[m] == 16'(exp_cyc), req_cyc, {"run length ", pat}, int'(rc[m]), exp_cyc);
        check(stalls == exp_stall, req_stall, {"input stalls ", pat}, stalls, exp_stall);
        check(dual_cnt[m] == exp_dual, req_dual, {"dual issue cycles ", pat}, dual_cnt[m], exp_dual);
        check(left_exp(m) == 0, "R3", {"unissued requests ", pat}, left_exp(m), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_errors++;
        $display("FAIL R7 watchdog: actual timeout expected drained run");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        n_checks = 0;
        n_errors = 0;
        next_tag = 1;
        for (int m = 0; m < 2; m++) begin
            rv[m] = 1'b0;
            rk[m] = 1'b0;
            rt[m] = '0;
            dual_cnt[m] = 0;
            last_v[m] = -1;
            last_t[m] = -1;
        end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        for (int m = 0; m < 2; m++) begin
            check(rr[m] == 1'b1, "R8", "ready after reset", int'(rr[m]), 1);
            check(!vi[m] && !ti[m], "R8", "no issue after reset", int'(vi[m]) + int'(ti[m]), 0);
            check(rc[m] == '0, "R8", "run count after reset", int'(rc[m]), 0);
            check(rd[m] == 1'b0, "R8", "done after reset", int'(rd[m]), 0);
        end

        // split queues: vertex burst fills its queue once (R1)
        run_seq(0, "VVVV", 9, 1, 0, "R7", "R1", "R5");
        // texture stream then a vertex; counter restarts (R9)
        run_seq(0, "TTTTV", 7, 0, 0, "R9", "R1", "R5");
        // blocked vertex head does not hold back texture (R5)
        run_seq(0, "VVVTTT", 7, 0, 1, "R5", "R1", "R5");

        // shared queue: same stream costs one more cycle (R6)
        run_seq(1, "VVVTTT", 8, 0, 1, "R6", "R2", "R6");
        // long vertex burst fills the shared queue (R2)
        run_seq(1, "VVVVVVVV", 17, 1, 0, "R9", "R2", "R6");
        run_seq(1, "TTTTV", 7, 0, 0, "R7", "R2", "R6");

        // drained result holds while idle (R7)
        begin
            logic [15:0] held0;
            logic [15:0] held1;
            held0 = rc[0];
            held1 = rc[1];
            repeat (5) @(negedge clk);
            #1;
            check(rc[0] == held0 && rd[0], "R7", "split result held", int'(rc[0]), int'(held0));
            check(rc[1] == held1 && rd[1], "R7", "shared result held", int'(rc[1]), int'(held1));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule